// File: doc/BRIEF.md
# Hard-Fault Diagnosis Error Counter Array

This block sits beside the retire stage of an out-of-order core and decides which field-deconfigurable resources have suffered a permanent fault. Examples of such resources are individual ALUs, reorder buffer entries and reservation station entries. Each retiring instruction presents a bit vector naming the resources it occupied. When the end-of-pipeline checker flags that instruction as wrong, the block cannot tell which resource caused the error, so it charges the error to all of them. Every resource has its own saturating error counter. A resource is switched off for good only once its count rises above the threshold programmed for its resource class. A single transient upset therefore does not cost the core any hardware.

The resources fall into three classes: ALUs first, then reorder-buffer entries, then reservation-station entries. Each class has its own threshold, so heavily shared resources can tolerate more charged errors than lightly used ones. A counter self-test port accepts a verdict on one counter at a time. If a counter is reported bad, its resource is pinned permanently on or permanently off, as a per-unit policy bit selects. The block presents a sticky disable vector to the pipeline, a two-bit status per unit, and the number of units currently disabled.

Top module: `hfd_fault_tracker`

## Requirements
- R1: After reset every counter is zero, every unit has status LIVE (2'b00), `unit_disable_o` is all zeros and `disabled_cnt_o` is zero.
- R2: A cycle with `retire_valid_i` and `chk_err_i` both high adds one to the counter of every LIVE unit whose `usage_i` bit is set. Counters of unused units do not change.
- R3: Nothing is charged when `retire_valid_i` is low, whatever `chk_err_i` and `usage_i` carry. Nothing is charged when `chk_err_i` is low.
- R4: Suppose a charge makes a unit's count strictly greater than its class threshold. Then that unit's status becomes TRIPPED (2'b01) and its `unit_disable_o` bit rises at the same clock edge that takes the charge. While the count is equal to or below the threshold, the unit stays LIVE.
- R5: `thr_cfg_i` holds one CNT_W-bit threshold per class, with class c at bits [c*CNT_W +: CNT_W]. Class 0 is the ALU units (indices 0..ALU_UNITS-1), class 1 is the reorder-buffer units (next ROB_UNITS indices) and class 2 is the reservation-station units (the remaining indices).
- R6: Counters saturate at 2^CNT_W-1 and never wrap. A unit charged past the maximum keeps the maximum count, so a threshold lowered later still trips it on its next charge.
- R7: A disabled unit stays disabled until reset, whatever the later retires, threshold changes or self-test verdicts.
- R8: When `st_req_i` and `st_bad_i` are high and `st_unit_i` names a LIVE unit, that unit becomes pinned. With its `st_policy_i` bit at 0 it becomes PINNED_ON (2'b10, enabled). With the bit at 1 it becomes PINNED_OFF (2'b11, disabled). If the unit is charged in the same cycle, the self-test verdict takes precedence. A verdict with `st_bad_i` low has no effect. So does a verdict naming a unit that is not LIVE or an index of NUM_UNITS or more.
- R9: A pinned unit keeps its status and ignores all later charges.
- R10: `unit_state_o[2*i +: 2]` gives unit i's status. `disabled_cnt_o` equals the number of set bits in `unit_disable_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_valid_i | input | 1 | An instruction retires this cycle |
| chk_err_i | input | 1 | Checker flags the retiring instruction as wrong |
| usage_i | input | NUM_UNITS | Units occupied by the retiring instruction |
| thr_cfg_i | input | 3*CNT_W | Per-class trip thresholds |
| st_req_i | input | 1 | Counter self-test verdict is present |
| st_unit_i | input | IDX_W | Unit the verdict refers to |
| st_bad_i | input | 1 | Verdict: the counter is faulty |
| st_policy_i | input | NUM_UNITS | Per-unit pin policy (1 = pin off) |
| unit_disable_o | output | NUM_UNITS | Sticky per-unit disable vector |
| unit_state_o | output | 2*NUM_UNITS | Per-unit status code |
| disabled_cnt_o | output | CNT_OUT_W | Number of disabled units |

## Verification
Every result of this block is due exactly one rising edge after its stimulus. A charge, a trip or a pin is taken at the edge that samples the inputs. The disable bits and status codes change at that same edge, and the disabled-unit count follows them combinationally with no extra delay. The bench drives inputs on the falling edge and compares all three outputs with its own model on the next falling edge. This puts each check half a period after the edge that should have changed the result, and before the next stimulus is applied.

// File: rtl/hfd_pkg.sv
package hfd_pkg;

  localparam int NUM_CLASSES = 3;

  typedef enum logic [1:0] {
    U_LIVE       = 2'b00,
    U_TRIPPED    = 2'b01,
    U_PINNED_ON  = 2'b10,
    U_PINNED_OFF = 2'b11
  } unit_state_e;

  // One saturating step of an error counter.
  function automatic int unsigned sat_step(input int unsigned v, input int unsigned maxv);
    return (v >= maxv) ? maxv : v + 1;
  endfunction

  // Trip rule: strictly above the threshold.
  function automatic logic over_limit(input int unsigned c, input int unsigned t);
    return c > t;
  endfunction

  // Resource class of a unit index: ALUs, then ROB entries, then RS entries.
  function automatic int class_of(input int idx, input int n_alu, input int n_rob);
    if (idx < n_alu) return 0;
    if (idx < n_alu + n_rob) return 1;
    return 2;
  endfunction

endpackage

// File: rtl/hfd_unit_slice.sv
module hfd_unit_slice
  import hfd_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             charge_i,
  input  logic [CNT_W-1:0] thr_i,
  input  logic             st_hit_i,
  input  logic             st_policy_i,
  output unit_state_e      state_o,
  output logic             disable_o
);

  localparam int unsigned MAXV = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  unit_state_e      state_q;

  logic             live;
  logic             pin_evt;
  logic             charge_evt;
  logic [CNT_W-1:0] cnt_inc;
  logic             trip_evt;

  assign live       = (state_q == U_LIVE);
  assign pin_evt    = st_hit_i && live;
  assign charge_evt = charge_i && live && !pin_evt;
  assign cnt_inc    = CNT_W'(sat_step(int'(cnt_q), MAXV));
  assign trip_evt   = charge_evt && over_limit(int'(cnt_inc), int'(thr_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      state_q <= U_LIVE;
    end else if (pin_evt) begin
      state_q <= st_policy_i ? U_PINNED_OFF : U_PINNED_ON;
    end else if (charge_evt) begin
      cnt_q <= cnt_inc;
      if (trip_evt) state_q <= U_TRIPPED;
    end
  end

  assign state_o   = state_q;
  assign disable_o = state_q[0];

  // R7
  sticky_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disable_o |=> disable_o);

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(MAXV)) |=> (cnt_q == CNT_W'(MAXV)));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !charge_i |=> $stable(cnt_q));

  // R4
  trip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == U_LIVE) ##1 (state_q == U_TRIPPED) |-> (cnt_q > $past(thr_i)));

  // R9
  pinned_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q[1] |=> ($stable(state_q) && $stable(cnt_q)));

endmodule

// File: rtl/hfd_popcount.sv
module hfd_popcount #(
  parameter int N = 19,
  parameter int W = $clog2(N + 1)
) (
  input  logic [N-1:0] vec_i,
  output logic [W-1:0] cnt_o
);

  always_comb begin
    cnt_o = '0;
    for (int k = 0; k < N; k++) cnt_o = cnt_o + W'(vec_i[k]);
  end

endmodule

// File: rtl/hfd_fault_tracker.sv
module hfd_fault_tracker
  import hfd_pkg::*;
#(
  parameter int ALU_UNITS = 4,
  parameter int ROB_UNITS = 8,
  parameter int RS_UNITS  = 7,
  parameter int CNT_W     = 4,
  localparam int NUM_UNITS = ALU_UNITS + ROB_UNITS + RS_UNITS,
  localparam int IDX_W     = $clog2(NUM_UNITS),
  localparam int CNT_OUT_W = $clog2(NUM_UNITS + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         retire_valid_i,
  input  logic                         chk_err_i,
  input  logic [NUM_UNITS-1:0]         usage_i,
  input  logic [NUM_CLASSES*CNT_W-1:0] thr_cfg_i,
  input  logic                         st_req_i,
  input  logic [IDX_W-1:0]             st_unit_i,
  input  logic                         st_bad_i,
  input  logic [NUM_UNITS-1:0]         st_policy_i,
  output logic [NUM_UNITS-1:0]         unit_disable_o,
  output logic [2*NUM_UNITS-1:0]       unit_state_o,
  output logic [CNT_OUT_W-1:0]         disabled_cnt_o
);

  logic                 err_retire;
  logic [NUM_UNITS-1:0] charge_vec;
  logic [NUM_UNITS-1:0] st_hit_vec;

  assign err_retire = retire_valid_i && chk_err_i;
  assign charge_vec = err_retire ? usage_i : '0;

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
    localparam int CL = class_of(i, ALU_UNITS, ROB_UNITS);
    unit_state_e st;

    assign st_hit_vec[i] = st_req_i && st_bad_i && (int'(st_unit_i) == i);

    hfd_unit_slice #(.CNT_W(CNT_W)) slice_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .charge_i   (charge_vec[i]),
      .thr_i      (thr_cfg_i[CL*CNT_W +: CNT_W]),
      .st_hit_i   (st_hit_vec[i]),
      .st_policy_i(st_policy_i[i]),
      .state_o    (st),
      .disable_o  (unit_disable_o[i])
    );

    assign unit_state_o[2*i +: 2] = st;
  end

  hfd_popcount #(.N(NUM_UNITS), .W(CNT_OUT_W)) pop_i (
    .vec_i(unit_disable_o),
    .cnt_o(disabled_cnt_o)
  );

  // R10
  dis_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(disabled_cnt_o) == $countones(unit_disable_o));

  // R3
  no_charge_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_valid_i |-> (charge_vec == '0));

  // R7
  disable_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((unit_disable_o & $past(unit_disable_o)) == $past(unit_disable_o)));

endmodule

// File: tb/hfd_fault_tracker_tb.sv
module hfd_fault_tracker_tb_top;

  localparam int N  = 19;
  localparam int CW = 4;
  localparam int MX = 15;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rv, ce, sr, sb;
  logic [N-1:0]  use_v;
  logic [4:0]    su;
  logic [N-1:0]  pol;
  logic [11:0]   thr_cfg;
  logic [N-1:0]  dis;
  logic [2*N-1:0] sta;
  logic [4:0]    dcnt;

  int thr [3];
  int mcnt[N];
  int mst [N];
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  assign thr_cfg = {thr[2][3:0], thr[1][3:0], thr[0][3:0]};

  hfd_fault_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .retire_valid_i(rv), .chk_err_i(ce),
    .usage_i(use_v), .thr_cfg_i(thr_cfg), .st_req_i(sr), .st_unit_i(su),
    .st_bad_i(sb), .st_policy_i(pol), .unit_disable_o(dis),
    .unit_state_o(sta), .disabled_cnt_o(dcnt)
  );

  function automatic int cls(input int i);
    if (i >= 12) return 2;
    return (i >= 4) ? 1 : 0;
  endfunction

  task automatic check_all(input string rq);
    logic [N-1:0]   edis = '0;
    logic [2*N-1:0] esta = '0;
    int             ecnt = 0;
    for (int i = 0; i < N; i++) begin
      esta[2*i +: 2] = 2'(mst[i]);
      edis[i] = (mst[i] == 1) || (mst[i] == 3);
      if (edis[i]) ecnt++;
    end
    checks += 3;
    if (dis !== edis) begin
      fails++; $display("FAIL %s disable actual=%h expected=%h", rq, dis, edis);
    end
    if (sta !== esta) begin
      fails++; $display("FAIL %s status actual=%h expected=%h", rq, sta, esta);
    end
    if (int'(dcnt) != ecnt) begin
      fails++; $display("FAIL %s R10 count actual=%0d expected=%0d", rq, dcnt, ecnt);
    end
  endtask

  // One cycle of stimulus, applied at a falling edge and checked at the next.
  task automatic step(input logic v, input logic e, input logic [N-1:0] u,
                      input logic q, input logic b, input int unit, input string rq);
    rv = v; ce = e; use_v = u; sr = q; sb = b; su = 5'(unit);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      if (q && b && unit == i && mst[i] == 0) mst[i] = pol[i] ? 3 : 2;
      else if (v && e && u[i] && mst[i] == 0) begin
        mcnt[i] = (mcnt[i] >= MX) ? MX : mcnt[i] + 1;
        if (mcnt[i] > thr[cls(i)]) mst[i] = 1;
      end
    end
    rv = 0; ce = 0; use_v = '0; sr = 0; sb = 0; su = '0;
    check_all(rq);
  endtask

  task automatic err(input logic [N-1:0] u, input string rq);
    step(1, 1, u, 0, 0, 0, rq);
  endtask

  task automatic t_reset;
    rst_n = 0; rv = 0; ce = 0; use_v = '0; sr = 0; sb = 0; su = '0;
    pol = '0; pol[7] = 1'b1;
    thr[0] = 2; thr[1] = 4; thr[2] = 1;
    for (int i = 0; i < N; i++) begin mcnt[i] = 0; mst[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1");
  endtask

  task automatic t_saturate;
    thr[0] = MX; thr[1] = MX; thr[2] = MX;
    for (int k = 0; k < 20; k++) err(19'h40010, "R6");
    thr[2] = 1; thr[1] = 4; thr[0] = 2;
    @(negedge clk);
    err(19'h40000, "R6");
  endtask

  task automatic t_charge;
    for (int k = 0; k < 2; k++) err(19'h01021, "R2");
  endtask

  task automatic t_ignore;
    for (int k = 0; k < 5; k++) step(0, 1, '1, 0, 0, 0, "R3");
    for (int k = 0; k < 5; k++) step(1, 0, '1, 0, 0, 0, "R3");
    err(19'h00001, "R3");
  endtask

  task automatic t_classes;
    for (int k = 0; k < 3; k++) err(19'h00002, "R5");
    for (int k = 0; k < 5; k++) err(19'h00040, "R4");
  endtask

  task automatic t_selftest;
    step(0, 0, '0, 1, 0, 3, "R8");
    step(0, 0, '0, 1, 1, 2, "R8");
    step(1, 1, 19'h00080, 1, 1, 7, "R8");
    step(0, 0, '0, 1, 1, 12, "R8");
    step(0, 0, '0, 1, 1, 25, "R8");
    for (int k = 0; k < 6; k++) err(19'h00084, "R9");
  endtask

  task automatic t_sticky;
    for (int k = 0; k < 6; k++) err('1, "R7");
    thr[0] = MX; thr[1] = MX; thr[2] = MX;
    step(0, 0, '0, 1, 1, 9, "R7");
    for (int k = 0; k < 4; k++) err('1, "R10");
  endtask

  initial begin
    t_reset();
    t_saturate();
    t_charge();
    t_ignore();
    t_classes();
    t_selftest();
    t_sticky();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule